// File: doc/BRIEF.md
# Bus Peripheral Security Gate

This block sits on an APB-style bus between a single upstream requester and sixteen downstream peripheral ports. The upstream address decode raises one bit of a one-hot select vector to pick the target port. In the same cycle, the gate checks the transfer's protection attributes against two configuration bits for that port. One bit admits non-secure accesses and the other admits unprivileged accesses. A transfer that passes is forwarded unchanged, and the chosen peripheral's response comes back to the requester.

A transfer that fails never reaches a peripheral: no downstream select or enable rises. The gate completes the transfer itself, in the same number of cycles a passing transfer would take. A response-select pin picks the outcome. When it is 1, the transfer ends with a bus error. When it is 0, the transfer reads as zero and any write is dropped. Each rejected access phase also sets a sticky pending flag. The flag drives an interrupt output that an enable pin can mask, and a clear pin resets it.

All configuration comes from input pins, apart from one elaboration-time mask. Each set bit in that mask exempts its port from the security comparison, so only the privilege check applies to that port. The block has no registers that software can reach.

Top module: `apb_sec_gate`

## Requirements
- R1: A transfer to a port that passes both checks is forwarded:
  - `dnSel` equals `upSel` and `dnEnable` equals `upEnable`.
  - `dnWrite`, `dnAddr` and `dnWdata` always mirror the upstream values.
  - `upRdata`, `upReady` and `upSlvErr` come from the selected port's slice. Port i uses bits [i*DW +: DW] of `dnRdata`, bit i of `dnReady` and bit i of `dnSlvErr`.
- R2: `upProt[1]` is the non-secure attribute (1 = non-secure). For a port whose mask bit is 0, the transfer is rejected if `upProt[1]` differs from that port's `cfgNonSec` bit. So a non-secure access to a port with `cfgNonSec`=0 is rejected, and a secure access to a port with `cfgNonSec`=1 is also rejected.
- R3: `upProt[0]` is the privileged attribute (1 = privileged). An access with `upProt[0]`=0 to a port whose `cfgUnpriv` bit is 0 is rejected. A privileged access is never rejected by the privilege check.
- R4: Ports whose bit is set in `SKIP_SEC_MASK` skip the R2 comparison, and only the R3 check applies to them.
- R5: While a transfer is rejected, `dnSel` is all zero and `dnEnable` is 0. `upReady` is 1, so a rejected transfer never inserts wait states.
- R6: For a rejected transfer, `upRdata` is 0. With `cfgErrResp`=1, `upSlvErr` equals `upEnable`. With `cfgErrResp`=0, `upSlvErr` is 0.
- R7: A rejected access phase (`upEnable`=1) sets the pending flag at the next clock edge, provided `irqClr` is 0 in that cycle. `irqOut` equals the pending flag ANDed with `irqEn`.
- R8: With `irqClr`=1, the flag is 0 after the edge, even if a rejection happens in the same cycle. A rejection in the first cycle with `irqClr`=0 sets it again.
- R9: While `rstN` is low, the pending flag is 0 and `irqOut` is 0.
- R10: With `upSel` all zero:
  - `dnSel` is zero and `dnEnable` is 0.
  - `upReady` is 1, `upSlvErr` is 0 and `upRdata` is 0.
  - The pending flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upSel | input | NP | One-hot port select from upstream decode |
| upEnable | input | 1 | Access-phase strobe |
| upWrite | input | 1 | 1 = write |
| upAddr | input | AW | Transfer address |
| upWdata | input | DW | Write data |
| upProt | input | 3 | Protection attributes: bit 0 privileged, bit 1 non-secure |
| upRdata | output | DW | Read data returned upstream |
| upReady | output | 1 | Transfer completion |
| upSlvErr | output | 1 | Bus error response |
| dnSel | output | NP | Per-port select to peripherals |
| dnEnable | output | 1 | Access strobe to peripherals |
| dnWrite | output | 1 | Forwarded write flag |
| dnAddr | output | AW | Forwarded address |
| dnWdata | output | DW | Forwarded write data |
| dnRdata | input | NP*DW | Packed read data, port i at [i*DW +: DW] |
| dnReady | input | NP | Per-port ready |
| dnSlvErr | input | NP | Per-port error |
| cfgNonSec | input | NP | Per-port: port serves non-secure accesses |
| cfgUnpriv | input | NP | Per-port: port admits unprivileged accesses |
| cfgErrResp | input | 1 | Rejected transfer response: 1 = error, 0 = read zero / drop write |
| irqEn | input | 1 | Interrupt enable |
| irqClr | input | 1 | Clears the pending flag |
| irqOut | output | 1 | Rejected-transfer interrupt |

## Verification
The bench aims at these cases:
- A secure access to a port that only serves non-secure traffic. A gate that merely blocks non-secure accesses would forward this one.
- The masked ports. A gate that ignored the mask would reject them on security grounds, and one that also skipped the privilege check would let unprivileged accesses through.
- Cycles in which a rejection coincides with the clear pin. A wrong priority here leaves the pending flag set.
- Rejected transfers that stall or leak. These show up as a wait state passed through from a peripheral, a stray downstream select, or nonzero read data in read-zero mode.

// File: rtl/gate_pkg.sv
package gate_pkg;
  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic anySel;   // some port is addressed
    logic fwd;      // transfer passes both checks
    logic blocked;  // transfer is rejected
    logic errResp;  // rejected transfers answer with an error
  } gateStrobe_t;
endpackage

// File: rtl/gate_ctl.sv
module gate_ctl
  import gate_pkg::*;
#(
  parameter int NP = 16,
  parameter logic [NP-1:0] SKIP_SEC_MASK = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NP-1:0] upSel,
  input  logic          upEnable,
  input  logic [2:0]    upProt,
  input  logic [NP-1:0] cfgNonSec,
  input  logic [NP-1:0] cfgUnpriv,
  input  logic          cfgErrResp,
  input  logic          irqEn,
  input  logic          irqClr,
  output gateStrobe_t   strb,
  output logic          irqOut
);
  localparam int PROT_PRIV = 0;
  localparam int PROT_NS   = 1;

  logic [NP-1:0] portOk;
  logic          pendQ;
  logic          pendD;

  // Per-port pass decision; the mask picks the variant at elaboration
  for (genvar i = 0; i < NP; i++) begin : g_port
    logic privOk;
    assign privOk = upProt[PROT_PRIV] | cfgUnpriv[i];
    if (SKIP_SEC_MASK[i]) begin : g_nosec
      assign portOk[i] = privOk;
    end else begin : g_sec
      assign portOk[i] = privOk & (cfgNonSec[i] == upProt[PROT_NS]);
    end
  end

  always_comb begin
    strb.anySel  = |upSel;
    // Any selected port that fails blocks the transfer
    strb.fwd     = strb.anySel && ((upSel & ~portOk) == '0);
    strb.blocked = strb.anySel && !strb.fwd;
    strb.errResp = cfgErrResp;
  end

  always_comb begin
    pendD = pendQ;
    if (irqClr)                           pendD = 1'b0;
    else if (strb.blocked && upEnable)    pendD = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= pendD;
  end

  assign irqOut = pendQ & irqEn;
endmodule

// File: rtl/gate_dp.sv
module gate_dp
  import gate_pkg::*;
#(
  parameter int NP = 16,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  gateStrobe_t      strb,
  input  logic [NP-1:0]    upSel,
  input  logic             upEnable,
  input  logic             upWrite,
  input  logic [AW-1:0]    upAddr,
  input  logic [DW-1:0]    upWdata,
  output logic [DW-1:0]    upRdata,
  output logic             upReady,
  output logic             upSlvErr,
  output logic [NP-1:0]    dnSel,
  output logic             dnEnable,
  output logic             dnWrite,
  output logic [AW-1:0]    dnAddr,
  output logic [DW-1:0]    dnWdata,
  input  logic [NP*DW-1:0] dnRdata,
  input  logic [NP-1:0]    dnReady,
  input  logic [NP-1:0]    dnSlvErr
);
  logic [DW-1:0] selRdata;
  logic          selReady;
  logic          selErr;

  // AND-OR response mux over the one-hot select
  always_comb begin
    selRdata = '0;
    for (int i = 0; i < NP; i++) begin
      selRdata = selRdata | (dnRdata[i*DW +: DW] & {DW{upSel[i]}});
    end
    selReady = |(dnReady & upSel);
    selErr   = |(dnSlvErr & upSel);
  end

  assign dnSel    = strb.fwd ? upSel : '0;
  assign dnEnable = strb.fwd & upEnable;
  assign dnWrite  = upWrite;
  assign dnAddr   = upAddr;
  assign dnWdata  = upWdata;

  always_comb begin
    if (strb.fwd) begin
      upRdata  = selRdata;
      upReady  = selReady;
      upSlvErr = selErr;
    end else begin
      upRdata  = '0;
      upReady  = 1'b1;
      upSlvErr = strb.blocked & strb.errResp & upEnable;
    end
  end
endmodule

// File: rtl/apb_sec_gate.sv
module apb_sec_gate
  import gate_pkg::*;
#(
  parameter int NP = 16,
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [NP-1:0] SKIP_SEC_MASK = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NP-1:0]    upSel,
  input  logic             upEnable,
  input  logic             upWrite,
  input  logic [AW-1:0]    upAddr,
  input  logic [DW-1:0]    upWdata,
  input  logic [2:0]       upProt,
  output logic [DW-1:0]    upRdata,
  output logic             upReady,
  output logic             upSlvErr,
  output logic [NP-1:0]    dnSel,
  output logic             dnEnable,
  output logic             dnWrite,
  output logic [AW-1:0]    dnAddr,
  output logic [DW-1:0]    dnWdata,
  input  logic [NP*DW-1:0] dnRdata,
  input  logic [NP-1:0]    dnReady,
  input  logic [NP-1:0]    dnSlvErr,
  input  logic [NP-1:0]    cfgNonSec,
  input  logic [NP-1:0]    cfgUnpriv,
  input  logic             cfgErrResp,
  input  logic             irqEn,
  input  logic             irqClr,
  output logic             irqOut
);
  gateStrobe_t strb;

  gate_ctl #(.NP(NP), .SKIP_SEC_MASK(SKIP_SEC_MASK)) u_ctl (
    .clk(clk), .rstN(rstN), .upSel(upSel), .upEnable(upEnable),
    .upProt(upProt), .cfgNonSec(cfgNonSec), .cfgUnpriv(cfgUnpriv),
    .cfgErrResp(cfgErrResp), .irqEn(irqEn), .irqClr(irqClr),
    .strb(strb), .irqOut(irqOut)
  );

  gate_dp #(.NP(NP), .AW(AW), .DW(DW)) u_dp (
    .strb(strb), .upSel(upSel), .upEnable(upEnable), .upWrite(upWrite),
    .upAddr(upAddr), .upWdata(upWdata), .upRdata(upRdata),
    .upReady(upReady), .upSlvErr(upSlvErr), .dnSel(dnSel),
    .dnEnable(dnEnable), .dnWrite(dnWrite), .dnAddr(dnAddr),
    .dnWdata(dnWdata), .dnRdata(dnRdata), .dnReady(dnReady),
    .dnSlvErr(dnSlvErr)
  );
endmodule

// File: rtl/gate_chk.sv
module gate_chk #(
  parameter int NP = 16,
  parameter int DW = 32,
  parameter logic [NP-1:0] SKIP_SEC_MASK = '0
) (
  input logic          clk,
  input logic          rstN,
  input logic [NP-1:0] upSel,
  input logic          upEnable,
  input logic [2:0]    upProt,
  input logic [DW-1:0] upRdata,
  input logic          upReady,
  input logic          upSlvErr,
  input logic [NP-1:0] dnSel,
  input logic          dnEnable,
  input logic [NP-1:0] cfgNonSec,
  input logic [NP-1:0] cfgUnpriv,
  input logic          cfgErrResp,
  input logic          irqEn,
  input logic          irqClr,
  input logic          irqOut
);
  logic rej;
  assign rej = (upSel != '0) && (dnSel == '0);

  p_fwd_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dnSel != '0) |-> (dnSel == upSel));
  p_ns_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upProt[1] && |(upSel & ~cfgNonSec & ~SKIP_SEC_MASK)) |-> (dnSel == '0));
  p_s_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!upProt[1] && |(upSel & cfgNonSec & ~SKIP_SEC_MASK)) |-> (dnSel == '0));
  p_priv_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!upProt[0] && |(upSel & ~cfgUnpriv)) |-> (dnSel == '0));
  p_rej_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    rej |-> (upReady && !dnEnable));
  p_rej_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    rej |-> (upRdata == '0 && upSlvErr == (cfgErrResp && upEnable)));
  p_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rej && upEnable && !irqClr) |=> (irqOut || !irqEn));
  p_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqClr |=> !irqOut);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (upSel == '0) |-> (dnSel == '0 && !dnEnable && upReady && !upSlvErr));
  always_comb begin
    if (!rstN) p_reset_r9: assert (!irqOut);
  end
endmodule

bind apb_sec_gate gate_chk #(.NP(NP), .DW(DW), .SKIP_SEC_MASK(SKIP_SEC_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .upSel(upSel), .upEnable(upEnable), .upProt(upProt),
  .upRdata(upRdata), .upReady(upReady), .upSlvErr(upSlvErr), .dnSel(dnSel),
  .dnEnable(dnEnable), .cfgNonSec(cfgNonSec), .cfgUnpriv(cfgUnpriv),
  .cfgErrResp(cfgErrResp), .irqEn(irqEn), .irqClr(irqClr), .irqOut(irqOut)
);

// File: tb/apb_sec_gate_tb.sv
`timescale 1ns/1ps
module apb_sec_gate_tb;
  localparam int NP = 16;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [NP-1:0] MASK = 16'h0C03;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] upSel = '0;
  logic upEnable = 1'b0, upWrite = 1'b0;
  logic [AW-1:0] upAddr = '0;
  logic [DW-1:0] upWdata = '0;
  logic [2:0] upProt = '0;
  logic [DW-1:0] upRdata;
  logic upReady, upSlvErr;
  logic [NP-1:0] dnSel;
  logic dnEnable, dnWrite;
  logic [AW-1:0] dnAddr;
  logic [DW-1:0] dnWdata;
  logic [NP*DW-1:0] dnRdata = '0;
  logic [NP-1:0] dnReady = '0, dnSlvErr = '0;
  logic [NP-1:0] cfgNonSec = '0, cfgUnpriv = '0;
  logic cfgErrResp = 1'b0, irqEn = 1'b0, irqClr = 1'b0;
  logic irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  bit mPend = 1'b0;
  bit lastClr = 1'b0;

  always #2.5 clk = ~clk;

  apb_sec_gate #(.NP(NP), .AW(AW), .DW(DW), .SKIP_SEC_MASK(MASK)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference decision, written from the requirements
  function automatic int selIdx();
    for (int i = 0; i < NP; i++) if (upSel[i]) return i;
    return -1;
  endfunction

  function automatic bit secFail(int i);
    if (MASK[i]) return 1'b0;
    return upProt[1] != cfgNonSec[i];
  endfunction

  function automatic bit privFail(int i);
    return !upProt[0] && !cfgUnpriv[i];
  endfunction

  function automatic bit isBlocked();
    int i = selIdx();
    if (i < 0) return 1'b0;
    return secFail(i) || privFail(i);
  endfunction

  always @(posedge clk) begin
    if (!rstN) mPend <= 1'b0;
    else if (irqClr) mPend <= 1'b0;
    else if (isBlocked() && upEnable) mPend <= 1'b1;
    lastClr <= irqClr;
  end

  always @(negedge clk) begin
    if (running) begin
      int i;
      string tag;
      bit blk;
      logic [NP-1:0] eSel;
      logic [DW-1:0] eRd;
      logic eRdy, eErr, eEn, eIrq;
      i = selIdx();
      blk = isBlocked();
      if (i < 0) tag = "R10";
      else if (!blk) tag = "R1";
      else if (secFail(i)) tag = "R2";
      else if (MASK[i]) tag = "R4";
      else tag = "R3";
      if (i < 0) begin
        eSel = '0; eEn = 1'b0; eRd = '0; eRdy = 1'b1; eErr = 1'b0;
      end else if (!blk) begin
        eSel = upSel; eEn = upEnable; eRd = dnRdata[i*DW +: DW];
        eRdy = dnReady[i]; eErr = dnSlvErr[i];
      end else begin
        eSel = '0; eEn = 1'b0; eRd = '0; eRdy = 1'b1;
        eErr = cfgErrResp && upEnable;
      end
      chk(dnSel == eSel, blk ? "R5" : tag, "dnSel", 64'(dnSel), 64'(eSel));
      chk(dnEnable == eEn, blk ? "R5" : tag, "dnEnable", 64'(dnEnable), 64'(eEn));
      chk(dnWrite == upWrite && dnAddr == upAddr && dnWdata == upWdata, "R1", "forward",
          {dnWrite, 19'(dnAddr), dnWdata}, {upWrite, 19'(upAddr), upWdata});
      chk(upReady == eRdy, blk ? "R5" : tag, "upReady", 64'(upReady), 64'(eRdy));
      chk(upSlvErr == eErr, blk ? "R6" : tag, "upSlvErr", 64'(upSlvErr), 64'(eErr));
      chk(upRdata == eRd, blk ? "R6" : tag, "upRdata", 64'(upRdata), 64'(eRd));
      eIrq = mPend && irqEn;
      chk(irqOut == eIrq, !rstN ? "R9" : (lastClr ? "R8" : "R7"), "irqOut",
          64'(irqOut), 64'(eIrq));
    end
  end

  task automatic randomStep(input int clrOdds, input int idleOdds);
    int p = $urandom_range(0, NP - 1);
    upSel = ($urandom_range(0, idleOdds) == 0) ? '0 : (NP'(1) << p);
    upEnable = 1'($urandom);
    upWrite = 1'($urandom);
    upAddr = AW'($urandom);
    upWdata = $urandom;
    upProt = 3'($urandom);
    for (int k = 0; k < NP; k++) dnRdata[k*DW +: DW] = $urandom;
    dnReady = NP'($urandom);
    dnSlvErr = NP'($urandom);
    irqEn = ($urandom_range(0, 3) != 0);
    irqClr = ($urandom_range(0, clrOdds) == 0);
  endtask

  initial begin
    running = 1'b1;
    // R9: reset state, with rejected traffic presented during reset
    cfgNonSec = '0; cfgUnpriv = '0; irqEn = 1'b1;
    upSel = 16'h0004; upEnable = 1'b1; upProt = 3'b010;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // Directed: R8 clear wins over simultaneous rejection
    irqClr = 1'b1;
    @(posedge clk); #1;
    irqClr = 1'b0;
    @(posedge clk); #1;
    // R2: secure access to a non-secure-only port
    upProt = 3'b001; cfgNonSec = 16'h0004; cfgUnpriv = '1;
    @(posedge clk); #1;
    // R4: masked port, unprivileged, not admitted
    upSel = 16'h0001; upProt = 3'b000; cfgUnpriv = '0; cfgErrResp = 1'b1;
    @(posedge clk); #1;
    for (int phase = 0; phase < 6; phase++) begin
      cfgNonSec = NP'($urandom);
      cfgUnpriv = NP'($urandom);
      cfgErrResp = phase[0];
      for (int c = 0; c < 600; c++) begin
        randomStep(phase < 3 ? 7 : 40, phase == 5 ? 1 : 8);
        @(posedge clk); #1;
      end
    end
    @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule